// File: doc/BRIEF.md
# Multicycle Processor Core with Buffered Branch Destination

This block is a small multicycle processor core executing a four-instruction subset of a 32-bit RISC instruction set: word load, word store, register add and branch-on-equal. Instructions and data share one memory reached through a single port. A single adder/subtractor does every arithmetic step: advancing the program counter, forming the branch destination, computing data addresses, adding operands and comparing for the branch.

A control state machine walks each instruction through a fixed sequence of states. The fetch state always advances the program counter by four. The decode state reads both source registers and, in the same cycle, computes a branch destination from the already-advanced counter and stores it in a dedicated destination register, before the opcode is known to be a branch. A branch then only compares its operands and, when they match, reloads the counter from that register. A memory-address select chooses between the program counter (fetch) and the latched ALU result (data access).

The memory attached to the port is expected to return read data combinationally for the address presented and to perform a write at the clock edge that ends a cycle with the write enable high.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` equals the reset address (default 0). The first cycle after reset release fetches from that address.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0]. Supported: opcode 0x23 load, 0x2B store, 0x04 branch-if-equal, and opcode 0x00 with funct 0x20 add.
- R3: Every instruction starts with one fetch cycle in which `mem_addr` is the program counter and no write occurs. The program counter then holds its old value plus 4.
- R4: A load writes the memory word at rs + sign-extended immediate into register rt. It takes five cycles, and its data read presents that computed address on `mem_addr`.
- R5: A store writes register rt to address rs + sign-extended immediate. `mem_we` is high for exactly one cycle, the fourth and last cycle of the instruction, with the address and data on the port.
- R6: An add writes rs + rt, modulo 2^32, into register rd and takes four cycles.
- R7: A branch-if-equal takes three cycles. The next fetch is at (branch address + 4) + (sign-extended immediate × 4) when rs equals rt, and at branch address + 4 otherwise. Backward destinations work.
- R8: Register 0 reads as zero. Loads and adds that target it have no visible effect.
- R9: Any other opcode, or opcode 0x00 with a funct other than 0x20, takes two cycles. It changes no register and no memory, and the next fetch is at its address + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for the shared memory, selected from program counter or ALU result |
| mem_wdata | output | 32 | Store data (register rt) |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 32 | Memory read data for the current `mem_addr` |

## Verification
The bench sweeps operand pairs that include zero, all-ones, the signed extremes and mixed bit patterns through add and through equal/unequal branches. It then checks both the stored result and the exact cycle of every fetch and write, so a wrong state count or a write strobe held too long shows up as a misplaced port event. A branch that builds its destination from the un-advanced counter, or omits the ×4 scaling, lands on the wrong store marker. An offset that is zero-extended rather than sign-extended sends the negative-offset load and store far outside the data area. A register file that lets register 0 hold a value stores a non-zero word where zero is expected. A decoder that ignores funct turns the subtract-encoded word into an add and corrupts the register saved afterwards.

// File: rtl/mc_pkg.sv
package mc_pkg;

   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_REG   = 6'h00;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] FN_ADD   = 6'h20;

   typedef enum logic [3:0] {
      ST_FETCH,
      ST_DECODE,
      ST_ADDR,
      ST_MEMRD,
      ST_LDWB,
      ST_MEMWR,
      ST_EXEC,
      ST_ALUWB,
      ST_BRANCH
   } mc_state_e;

   typedef enum logic       { AMUX_PC, AMUX_RA } amux_e;
   typedef enum logic [1:0] { BMUX_STEP, BMUX_IMM, BMUX_BROFF, BMUX_RB } bmux_e;
   typedef enum logic       { ALU_ADD, ALU_SUB } aluop_e;
   typedef enum logic       { PCSEL_ALU, PCSEL_TGT } pcsel_e;

   typedef struct packed {
      logic   addr_data;   // 1: memory addressed by latched ALU result
      logic   mem_we;
      logic   ir_en;
      logic   mdr_en;
      logic   pc_en;
      pcsel_e pc_sel;
      logic   tgt_en;
      logic   opnd_en;
      logic   res_en;
      logic   rf_we;
      logic   rf_dst_rd;
      logic   rf_from_mdr;
      amux_e  amux;
      bmux_e  bmux;
      aluop_e aluop;
   } mc_ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  aluop_e       op,
   output logic [W-1:0] y,
   output logic         zero
);

   logic [W-1:0] b_eff;
   logic         cin;

   always_comb begin
      b_eff = (op == ALU_SUB) ? ~b : b;
      cin   = (op == ALU_SUB);
      y     = a + b_eff + W'(cin);
      zero  = (y == '0);
   end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W        = 32,
   parameter int DEPTH    = 32,
   parameter int NRD      = 2,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           wa,
   input  logic [W-1:0]            wd,
   input  logic [NRD-1:0][AW-1:0]  ra,
   output logic [NRD-1:0][W-1:0]   rd
);

   logic [W-1:0] regs [DEPTH];
   logic         wr_ok;

   assign wr_ok = we && (!ZERO_REG || (wa != '0));

   always_ff @(posedge clk) begin
      if (wr_ok) regs[wa] <= wd;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (ZERO_REG) begin : g_zero
         assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
      end else begin : g_plain
         assign rd[p] = regs[ra[p]];
      end
   end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic      alu_zero,
   output mc_state_e state_o,
   output mc_ctrl_t  ctl_o
);

   mc_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_FETCH;
      else        state_q <= state_d;
   end

   always_comb begin
      ctl_o   = '0;
      state_d = ST_FETCH;
      unique case (state_q)
         ST_FETCH: begin
            ctl_o.ir_en  = 1'b1;
            ctl_o.pc_en  = 1'b1;
            ctl_o.pc_sel = PCSEL_ALU;
            ctl_o.amux   = AMUX_PC;
            ctl_o.bmux   = BMUX_STEP;
            ctl_o.aluop  = ALU_ADD;
            state_d      = ST_DECODE;
         end
         ST_DECODE: begin
            ctl_o.opnd_en = 1'b1;
            ctl_o.tgt_en  = 1'b1;
            ctl_o.amux    = AMUX_PC;
            ctl_o.bmux    = BMUX_BROFF;
            ctl_o.aluop   = ALU_ADD;
            if (opcode == OP_LOAD || opcode == OP_STORE) state_d = ST_ADDR;
            else if (opcode == OP_BEQ)                    state_d = ST_BRANCH;
            else if (opcode == OP_REG && funct == FN_ADD) state_d = ST_EXEC;
            else                                          state_d = ST_FETCH;
         end
         ST_ADDR: begin
            ctl_o.res_en = 1'b1;
            ctl_o.amux   = AMUX_RA;
            ctl_o.bmux   = BMUX_IMM;
            ctl_o.aluop  = ALU_ADD;
            state_d      = (opcode == OP_LOAD) ? ST_MEMRD : ST_MEMWR;
         end
         ST_MEMRD: begin
            ctl_o.addr_data = 1'b1;
            ctl_o.mdr_en    = 1'b1;
            state_d         = ST_LDWB;
         end
         ST_LDWB: begin
            ctl_o.rf_we       = 1'b1;
            ctl_o.rf_from_mdr = 1'b1;
            ctl_o.rf_dst_rd   = 1'b0;
            state_d           = ST_FETCH;
         end
         ST_MEMWR: begin
            ctl_o.addr_data = 1'b1;
            ctl_o.mem_we    = 1'b1;
            state_d         = ST_FETCH;
         end
         ST_EXEC: begin
            ctl_o.res_en = 1'b1;
            ctl_o.amux   = AMUX_RA;
            ctl_o.bmux   = BMUX_RB;
            ctl_o.aluop  = ALU_ADD;
            state_d      = ST_ALUWB;
         end
         ST_ALUWB: begin
            ctl_o.rf_we     = 1'b1;
            ctl_o.rf_dst_rd = 1'b1;
            state_d         = ST_FETCH;
         end
         ST_BRANCH: begin
            ctl_o.amux   = AMUX_RA;
            ctl_o.bmux   = BMUX_RB;
            ctl_o.aluop  = ALU_SUB;
            ctl_o.pc_sel = PCSEL_TGT;
            ctl_o.pc_en  = alu_zero;
            state_d      = ST_FETCH;
         end
         default: state_d = ST_FETCH;
      endcase
   end

   assign state_o = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              NREGS    = 32,
   parameter logic [31:0]     RESET_PC = 32'h0,
   parameter int              PC_STEP  = 4,
   parameter bit              ZERO_REG = 1'b1,
   localparam int             RA_W     = $clog2(NREGS),
   localparam int             IMM_W    = 16,
   localparam int             BR_SHL   = 2,
   localparam int             EXT_W    = XLEN - IMM_W
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_we,
   input  logic [XLEN-1:0] mem_rdata
);

   initial begin : elab_checks
      assert (XLEN == 32)
         else $error("mc_core: instruction fields need XLEN of 32");
      assert (NREGS == (1 << RA_W) && RA_W <= 5)
         else $error("mc_core: NREGS must be a power of two up to 32");
      assert (PC_STEP > 0 && PC_STEP < (1 << IMM_W))
         else $error("mc_core: PC_STEP out of range");
   end

   mc_ctrl_t  ctl;
   mc_state_e state_w;

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, opa_q, opb_q, res_q, tgt_q;
   logic [XLEN-1:0] alu_a, alu_b, alu_y;
   logic            alu_zero;
   logic [XLEN-1:0] imm_sx, br_off;
   logic [5:0]      op_w, fn_w;
   logic [4:0]      rs_w, rt_w, rd_w;
   logic [1:0][RA_W-1:0] rf_ra;
   logic [1:0][XLEN-1:0] rf_rd;
   logic [RA_W-1:0] rf_wa;
   logic [XLEN-1:0] rf_wd;

   assign op_w   = ir_q[31:26];
   assign rs_w   = ir_q[25:21];
   assign rt_w   = ir_q[20:16];
   assign rd_w   = ir_q[15:11];
   assign fn_w   = ir_q[5:0];
   assign imm_sx = {{EXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign br_off = imm_sx << BR_SHL;

   mc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .opcode   (op_w),
      .funct    (fn_w),
      .alu_zero (alu_zero),
      .state_o  (state_w),
      .ctl_o    (ctl)
   );

   always_comb begin
      alu_a = (ctl.amux == AMUX_PC) ? pc_q : opa_q;
      unique case (ctl.bmux)
         BMUX_STEP:  alu_b = XLEN'(PC_STEP);
         BMUX_IMM:   alu_b = imm_sx;
         BMUX_BROFF: alu_b = br_off;
         default:    alu_b = opb_q;
      endcase
   end

   mc_alu #(.W(XLEN)) u_alu (
      .a    (alu_a),
      .b    (alu_b),
      .op   (ctl.aluop),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign rf_ra[0] = rs_w[RA_W-1:0];
   assign rf_ra[1] = rt_w[RA_W-1:0];
   assign rf_wa    = ctl.rf_dst_rd ? rd_w[RA_W-1:0] : rt_w[RA_W-1:0];
   assign rf_wd    = ctl.rf_from_mdr ? mdr_q : res_q;

   mc_regfile #(
      .W        (XLEN),
      .DEPTH    (NREGS),
      .NRD      (2),
      .ZERO_REG (ZERO_REG)
   ) u_rf (
      .clk (clk),
      .we  (ctl.rf_we),
      .wa  (rf_wa),
      .wd  (rf_wd),
      .ra  (rf_ra),
      .rd  (rf_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         mdr_q <= '0;
         opa_q <= '0;
         opb_q <= '0;
         res_q <= '0;
         tgt_q <= '0;
      end else begin
         if (ctl.pc_en)   pc_q  <= (ctl.pc_sel == PCSEL_TGT) ? tgt_q : alu_y;
         if (ctl.ir_en)   ir_q  <= mem_rdata;
         if (ctl.mdr_en)  mdr_q <= mem_rdata;
         if (ctl.opnd_en) begin
            opa_q <= rf_rd[0];
            opb_q <= rf_rd[1];
         end
         if (ctl.res_en)  res_q <= alu_y;
         if (ctl.tgt_en)  tgt_q <= alu_y;
      end
   end

   assign mem_addr  = ctl.addr_data ? res_q : pc_q;
   assign mem_wdata = opb_q;
   assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
   import mc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int PC_STEP  = 4,
   parameter bit ZERO_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input mc_state_e       state,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] tgt_q,
   input logic [XLEN-1:0] opa_q,
   input logic [XLEN-1:0] opb_q,
   input logic [XLEN-1:0] res_q,
   input logic [XLEN-1:0] mem_addr,
   input logic            mem_we,
   input logic [5:0]      op,
   input logic [5:0]      fn,
   input logic [4:0]      rs
);

   logic unsupported;
   assign unsupported = !(op == 6'h23 || op == 6'h2B || op == 6'h04 ||
                          (op == 6'h00 && fn == 6'h20));

   AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |-> (mem_addr == pc_q && !mem_we)); // R3

   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(PC_STEP))); // R3

   AST_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MEMRD || state == ST_MEMWR) |-> (mem_addr == res_q)); // R4

   AST_LOAD_END: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LDWB) |=> (state == ST_FETCH)); // R4

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R5

   AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRANCH && opa_q == opb_q) |=> (pc_q == $past(tgt_q))); // R7

   AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRANCH && opa_q != opb_q) |=> $stable(pc_q)); // R7

   AST_SKIP_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && unsupported) |=> (state == ST_FETCH)); // R9

   if (ZERO_REG) begin : g_zero_chk
      AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (state == ST_DECODE && rs == 5'd0) |=> (opa_q == '0)); // R8
   end

endmodule

bind mc_core mc_core_chk #(
   .XLEN     (XLEN),
   .PC_STEP  (PC_STEP),
   .ZERO_REG (ZERO_REG)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state_w),
   .pc_q     (pc_q),
   .tgt_q    (tgt_q),
   .opa_q    (opa_q),
   .opb_q    (opb_q),
   .res_q    (res_q),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .op       (op_w),
   .fn       (fn_w),
   .rs       (rs_w)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we;

   always #4 clk = ~clk;   // 125 MHz

   logic [31:0] mem [0:255];
   logic        tb_ld = 1'b0;
   logic [7:0]  tb_idx = '0;
   logic [31:0] tb_val = '0;

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (tb_ld)       mem[tb_idx] <= tb_val;
      else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
   end

   mc_core dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   int total = 0;
   int bad   = 0;

   logic [31:0] a_log [0:63];
   logic [31:0] d_log [0:63];
   logic        w_log [0:63];

   localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                        32'h8000_0000, 32'h1234_5678, 32'h0000_FFFF,
                                        32'hA5A5_A5A5};

   function automatic logic [31:0] e_lw(input int rt, input int rs, input logic [15:0] imm);
      return {6'h23, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] e_sw(input int rt, input int rs, input logic [15:0] imm);
      return {6'h2B, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] e_add(input int rd, input int rs, input int rt);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
   endfunction
   function automatic logic [31:0] e_beq(input int rs, input int rt, input logic [15:0] imm);
      return {6'h04, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input int idx, input logic [31:0] val);
      tb_ld  = 1'b1;
      tb_idx = 8'(idx);
      tb_val = val;
      @(posedge clk);
      #1 tb_ld = 1'b0;
   endtask

   task automatic clear_data();
      for (int i = 128; i < 144; i++) poke(i, 32'h0);
   endtask

   // release reset at a negedge; cycle 0 is the first fetch
   task automatic run_prog(input int ncyc);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < ncyc; k++) begin
         #1;
         a_log[k] = mem_addr;
         w_log[k] = mem_we;
         d_log[k] = mem_wdata;
         @(negedge clk);
      end
      rst_n = 1'b0;
      #1;
      chk(mem_we == 1'b0 && mem_addr == 32'h0, "R1 reset state after run", mem_addr, 32'h0);
   endtask

   function automatic int count_writes(input int ncyc);
      int n = 0;
      for (int k = 0; k < ncyc; k++) if (w_log[k]) n++;
      return n;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] x, y;
      // R1: reset state
      repeat (2) @(negedge clk);
      #1;
      chk(mem_we == 1'b0, "R1 no write in reset", 32'(mem_we), 32'h0);
      chk(mem_addr == 32'h0, "R1 reset address", mem_addr, 32'h0);

      // R2 R4 R5 R6: add sweep (load, load, add, store, spin)
      poke(0, e_lw(1, 0, 16'h0200));
      poke(1, e_lw(2, 0, 16'h0204));
      poke(2, e_add(3, 1, 2));
      poke(3, e_sw(3, 0, 16'h0208));
      poke(4, e_beq(0, 0, 16'hFFFF));
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            x = VALS[i];
            y = VALS[j];
            clear_data();
            poke(128, x);
            poke(129, y);
            run_prog(26);
            chk(a_log[0] == 32'h0, "R1 first fetch", a_log[0], 32'h0);
            chk(a_log[5] == 32'h4, "R3 R4 load is five cycles", a_log[5], 32'h4);
            chk(a_log[10] == 32'h8, "R4 second load length", a_log[10], 32'h8);
            chk(a_log[14] == 32'hC, "R6 add is four cycles", a_log[14], 32'hC);
            chk(a_log[18] == 32'h10, "R5 store is four cycles", a_log[18], 32'h10);
            chk(a_log[21] == 32'h10 && a_log[24] == 32'h10, "R7 backward branch",
                a_log[21], 32'h10);
            chk(count_writes(26) == 1, "R5 single write strobe", 32'(count_writes(26)), 32'h1);
            chk(w_log[17] && a_log[17] == 32'h208, "R5 store address and cycle",
                a_log[17], 32'h208);
            chk(d_log[17] == x + y, "R2 R6 add result", d_log[17], x + y);
            chk(mem[130] == x + y, "R5 memory updated", mem[130], x + y);
         end
      end

      // R7: branch taken / not taken sweep
      poke(0, e_lw(1, 0, 16'h0200));
      poke(1, e_lw(2, 0, 16'h0204));
      poke(2, e_beq(1, 2, 16'h0001));
      poke(3, e_sw(1, 0, 16'h0210));
      poke(4, e_sw(2, 0, 16'h0214));
      poke(5, e_beq(0, 0, 16'hFFFF));
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            x = VALS[i];
            y = VALS[j];
            clear_data();
            poke(128, x);
            poke(129, y);
            run_prog(28);
            if (x == y) begin
               chk(a_log[13] == 32'h10, "R7 taken destination", a_log[13], 32'h10);
               chk(count_writes(28) == 1, "R7 taken skips store", 32'(count_writes(28)), 32'h1);
               chk(w_log[16] && a_log[16] == 32'h214 && d_log[16] == y,
                   "R7 taken store", a_log[16], 32'h214);
            end else begin
               chk(a_log[13] == 32'hC, "R7 not taken falls through", a_log[13], 32'hC);
               chk(count_writes(28) == 2, "R7 not taken both stores", 32'(count_writes(28)), 32'h2);
               chk(w_log[16] && a_log[16] == 32'h210 && d_log[16] == x,
                   "R7 first store", a_log[16], 32'h210);
               chk(w_log[20] && a_log[20] == 32'h214 && d_log[20] == y,
                   "R7 second store", a_log[20], 32'h214);
            end
         end
      end

      // R8 R9: register 0 and unsupported encodings
      poke(0, e_lw(1, 0, 16'h0200));
      poke(1, e_add(0, 1, 1));
      poke(2, e_sw(0, 0, 16'h020C));
      poke(3, e_lw(0, 0, 16'h0200));
      poke(4, e_sw(0, 0, 16'h0210));
      poke(5, 32'hFC00_0000);
      poke(6, {6'h00, 5'd1, 5'd1, 5'd1, 5'd0, 6'h22});
      poke(7, e_sw(1, 0, 16'h0214));
      poke(8, e_beq(0, 0, 16'hFFFF));
      clear_data();
      poke(128, 32'h1234_5678);
      run_prog(34);
      chk(w_log[12] && a_log[12] == 32'h20C && d_log[12] == 32'h0,
          "R8 add into r0 ignored", d_log[12], 32'h0);
      chk(w_log[21] && a_log[21] == 32'h210 && d_log[21] == 32'h0,
          "R8 load into r0 ignored", d_log[21], 32'h0);
      chk(a_log[22] == 32'h14 && a_log[24] == 32'h18 && a_log[26] == 32'h1C,
          "R9 unsupported takes two cycles", a_log[26], 32'h1C);
      chk(w_log[29] && a_log[29] == 32'h214 && d_log[29] == 32'h1234_5678,
          "R9 unsupported leaves register", d_log[29], 32'h1234_5678);
      chk(count_writes(34) == 3, "R9 no extra writes", 32'(count_writes(34)), 32'h3);

      // R4 R5: negative offsets
      poke(0, e_lw(5, 0, 16'h0200));
      poke(1, e_lw(6, 5, 16'hFFF8));
      poke(2, e_sw(6, 5, 16'hFFFC));
      poke(3, e_beq(0, 0, 16'hFFFF));
      clear_data();
      poke(128, 32'h0000_0220);
      poke(134, 32'hCAFE_F00D);
      run_prog(20);
      chk(w_log[13] && a_log[13] == 32'h21C, "R5 negative store offset", a_log[13], 32'h21C);
      chk(d_log[13] == 32'hCAFE_F00D, "R4 negative load offset", d_log[13], 32'hCAFE_F00D);
      chk(mem[135] == 32'hCAFE_F00D, "R5 stored word", mem[135], 32'hCAFE_F00D);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule